// File: doc/BRIEF.md
# Typed Instruction Dispatch Queues

This block takes decoded instructions one at a time, in program order, over a valid/ready handshake. Each carries a 3-bit class field and a payload. Scalar instructions are executed at once: the block raises a one-cycle execute strobe in the same cycle the instruction is accepted, and the instruction is never stored. Every other legal class is written into one of five independent in-order queues. The queues are vector, matrix, and three data-movement classes that are split by the source and destination of the move. A class code outside the legal set is accepted, reported on an error strobe, and discarded.

Each queue presents its oldest entry to its own execution-unit port. An entry leaves the queue only in a cycle where that unit's ready (idle) input is high. Queues drain independently of each other. Intake is strictly in order. When the queue targeted by the instruction at the input is full, input ready goes low and the instruction waits, even if other queues have room.

Every queue is a small state machine with three states:
- Q_EMPTY: no entries held.
- Q_PART: some entries held, but fewer than the depth.
- Q_FULL: the queue holds exactly its depth.

The transitions are:
- FILL: Q_EMPTY to Q_PART, on a write.
- TOP: Q_PART to Q_FULL, on a write with no issue while one slot is left.
- DRAIN: Q_PART to Q_EMPTY, on an issue with no write while one entry is left.
- RELEASE: Q_FULL to Q_PART, on an issue.
- With a depth of one, FILL goes straight to Q_FULL and RELEASE goes straight to Q_EMPTY.
- A simultaneous write and issue in Q_PART keeps the state.

Top module: `typed_dispatch`

## Requirements
- R1: After reset, every queue output valid is 0, input ready is 1, and the scalar and error strobes are 0.
- R2: Class 0 (scalar) is accepted in the cycle it is presented. In that same cycle, scalar_fire is 1 and scalar_payload equals the input payload. No queue output becomes valid as a result.
- R3: Classes 1 to 5 are written to output ports 0 to 4 respectively, and the port's valid rises in the cycle after acceptance. The port mapping is:
  - port 0: vector, class 1.
  - port 1: matrix, class 2.
  - port 2: moves from the large local buffer into the matrix-input or unified buffers, or matrix-input buffer initialisation from a configuration register; class 3.
  - port 3: moves from global memory into local, matrix-input or unified buffers; class 4.
  - port 4: moves from the unified buffer to global memory; class 5.
- R4: Classes 6 and 7 are accepted. In the acceptance cycle bad_class is 1, and the instruction reaches no queue and does not fire as scalar.
- R5: Within one queue, entries leave in exactly their arrival order.
- R6: An entry leaves a queue only in a cycle where that port's out_ready is 1. While out_ready is 0, valid and payload stay unchanged.
- R7: When the input targets a full queue, in_ready is 0, nothing is accepted, and no other port is written.
- R8: A queue whose unit is busy does not prevent other queues from issuing.
- R9: Each queue accepts exactly DEPTH entries before refusing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present at the input |
| in_ready | output | 1 | Instruction is taken this cycle when in_valid is high |
| in_class | input | 3 | Class code: 0 scalar, 1 vector, 2 matrix, 3 to 5 move classes |
| in_payload | input | PW | Instruction payload |
| scalar_fire | output | 1 | One-cycle strobe that executes a scalar instruction now |
| scalar_payload | output | PW | Payload of the scalar instruction |
| bad_class | output | 1 | One-cycle strobe: an illegal class was accepted and dropped |
| out_valid | output | 5 | Per-port: queue holds an entry |
| out_ready | input | 5 | Per-port: execution unit idle, so the head entry is taken |
| out_payload | output | 5*PW | Head payload per port, port k at bits [k*PW +: PW] |

## Verification
The hardest situation to reach from the ports is one where a queue is exactly full while its unit stays busy, and the instruction at the input still targets it. Intake must stall, but the other ports must keep working. The stimulus holds one port's out_ready low, writes DEPTH entries of distinct payloads to that port, and then presents one more. It then fills a second queue partly and drains only the second one. This shows that the blocked queue neither gives up its head nor stops its neighbour.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int NUM_QUEUES = 5;

    typedef enum logic [2:0] {
        CLS_SCALAR = 3'd0,
        CLS_VEC    = 3'd1,
        CLS_MAT    = 3'd2,
        CLS_MV1    = 3'd3,
        CLS_MV2    = 3'd4,
        CLS_MV3    = 3'd5
    } insn_class_e;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PART,
        Q_FULL
    } qstate_e;
endpackage

// File: rtl/dq_route.sv
module dq_route
    import dq_pkg::*;
(
    input  logic                  in_valid,
    input  logic [2:0]            in_class,
    input  logic [NUM_QUEUES-1:0] q_full,
    output logic                  ready,
    output logic                  is_scalar,
    output logic                  is_bad,
    output logic [NUM_QUEUES-1:0] push
);
    logic [NUM_QUEUES-1:0] target;

    always_comb begin
        target    = '0;
        is_scalar = 1'b0;
        is_bad    = 1'b0;
        case (in_class)
            CLS_SCALAR: is_scalar = 1'b1;
            CLS_VEC:    target[0] = 1'b1;
            CLS_MAT:    target[1] = 1'b1;
            CLS_MV1:    target[2] = 1'b1;
            CLS_MV2:    target[3] = 1'b1;
            CLS_MV3:    target[4] = 1'b1;
            default:    is_bad    = 1'b1;
        endcase
    end

    assign ready = ((target & q_full) == '0);
    assign push  = (in_valid && ready) ? target : '0;
endmodule

// File: rtl/dq_queue.sv
module dq_queue
    import dq_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    qstate_e       state, state_nxt;
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          pop;

    assign pop = out_valid && pop_ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: if (push) state_nxt = (DEPTH == 1) ? Q_FULL : Q_PART;
            Q_PART: begin
                if (push && !pop && count == CW'(DEPTH - 1)) state_nxt = Q_FULL;
                else if (pop && !push && count == CW'(1))    state_nxt = Q_EMPTY;
            end
            Q_FULL:  if (pop) state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_PART;
            default: state_nxt = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= Q_EMPTY;
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            state <= state_nxt;
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_comb begin
        out_valid = 1'b0;
        full      = 1'b0;
        unique case (state)
            Q_EMPTY: ;
            Q_PART:  out_valid = 1'b1;
            Q_FULL: begin
                out_valid = 1'b1;
                full      = 1'b1;
            end
            default: ;
        endcase
    end

    assign out_data = mem[rd_ptr];

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> state != Q_FULL);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop_ready && !$past(!rst_n)) |=> (out_valid && $stable(out_data)));
    assert_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) |-> (count == CW'(DEPTH)));
endmodule

// File: rtl/typed_dispatch.sv
module typed_dispatch
    import dq_pkg::*;
#(
    parameter int PW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [2:0]               in_class,
    input  logic [PW-1:0]            in_payload,
    output logic                     scalar_fire,
    output logic [PW-1:0]            scalar_payload,
    output logic                     bad_class,
    output logic [NUM_QUEUES-1:0]    out_valid,
    input  logic [NUM_QUEUES-1:0]    out_ready,
    output logic [NUM_QUEUES*PW-1:0] out_payload
);
    logic [NUM_QUEUES-1:0] q_full, push;
    logic                  is_scalar, is_bad;

    dq_route u_route (
        .in_valid (in_valid),
        .in_class (in_class),
        .q_full   (q_full),
        .ready    (in_ready),
        .is_scalar(is_scalar),
        .is_bad   (is_bad),
        .push     (push)
    );

    assign scalar_fire    = in_valid && is_scalar;
    assign scalar_payload = in_payload;
    assign bad_class      = in_valid && is_bad;

    for (genvar k = 0; k < NUM_QUEUES; k++) begin : g_q
        dq_queue #(.W(PW), .DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[k]),
            .push_data(in_payload),
            .pop_ready(out_ready[k]),
            .out_valid(out_valid[k]),
            .out_data (out_payload[k*PW +: PW]),
            .full     (q_full[k])
        );
    end

    assert_scalar_unqueued_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scalar_fire |-> (push == '0 && in_ready));
    assert_bad_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_class |-> (push == '0 && !scalar_fire && in_ready));
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));
    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> (push == '0 && !scalar_fire && !bad_class));
endmodule

// File: tb/typed_dispatch_tb.sv
module typed_dispatch_tb;
    localparam int PW    = 8;
    localparam int DEPTH = 4;
    localparam int NQ    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_class = '0;
    logic [PW-1:0] in_payload = '0;
    logic          scalar_fire;
    logic [PW-1:0] scalar_payload;
    logic          bad_class;
    logic [NQ-1:0] out_valid;
    logic [NQ-1:0] out_ready = '0;
    logic [NQ*PW-1:0] out_payload;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    typed_dispatch #(.PW(PW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_payload(in_payload), .scalar_fire(scalar_fire),
        .scalar_payload(scalar_payload), .bad_class(bad_class),
        .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int port_pay(input int k);
        return int'(out_payload[k*PW +: PW]);
    endfunction

    // Present one instruction at a negedge, sample combinational outputs, commit at posedge.
    task automatic send(input int c, input int p, output bit took, output bit sf,
                        output int sp, output bit bc);
        @(negedge clk);
        in_valid = 1'b1; in_class = 3'(c); in_payload = PW'(p);
        #1;
        took = in_ready; sf = scalar_fire; sp = int'(scalar_payload); bc = bad_class;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Take the head of port k; returns the payload seen before the edge.
    task automatic take(input int k, output int p);
        @(negedge clk);
        out_ready[k] = 1'b1;
        #1;
        p = port_pay(k);
        @(posedge clk); #1;
        out_ready[k] = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit took, sf, bc;
        int sp, got;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 scalar_fire", int'(scalar_fire), 0);
        check("R1 bad_class", int'(bad_class), 0);

        // Sweep every class code with several payloads
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 4; p++) begin
                int pay = (c * 37 + p * 61 + 5) & 8'hff;
                send(c, pay, took, sf, sp, bc);
                check("R2/R3/R4 accepted", int'(took), 1);
                check("R2 scalar_fire", int'(sf), (c == 0) ? 1 : 0);
                if (c == 0) check("R2 scalar_payload", sp, pay);
                check("R4 bad_class", int'(bc), (c > 5) ? 1 : 0);
                @(negedge clk);
                check("R3 port select", int'(out_valid),
                      (c >= 1 && c <= 5) ? (1 << (c - 1)) : 0);
                if (c >= 1 && c <= 5) begin
                    check("R3 payload", port_pay(c - 1), pay);
                    take(c - 1, got);
                    @(negedge clk);
                    check("R6 emptied after take", int'(out_valid), 0);
                end
            end
        end

        // Fill each queue, check stall, then drain in order
        for (int k = 0; k < NQ; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                send(k + 1, 16 * k + i + 1, took, sf, sp, bc);
                check("R9 entry accepted", int'(took), 1);
            end
            send(k + 1, 8'hee, took, sf, sp, bc);
            check("R7 full refuses", int'(took), 0);
            @(negedge clk);
            check("R7 only target valid", int'(out_valid), 1 << k);
            check("R6 head held", port_pay(k), 16 * k + 1);
            for (int i = 0; i < DEPTH; i++) begin
                take(k, got);
                check("R5 order", got, 16 * k + i + 1);
            end
            @(negedge clk);
            check("R9 drained", int'(out_valid), 0);
        end

        // R8: port 0 busy and full, port 1 drains past it
        for (int i = 0; i < DEPTH; i++) send(1, 100 + i, took, sf, sp, bc);
        send(2, 200, took, sf, sp, bc);
        send(2, 201, took, sf, sp, bc);
        repeat (3) @(negedge clk);
        check("R6 busy unit keeps head", port_pay(0), 100);
        take(1, got); check("R8 independent issue", got, 200);
        take(1, got); check("R8 independent issue", got, 201);
        @(negedge clk);
        check("R8 busy queue untouched", int'(out_valid), 1);
        check("R8 busy head", port_pay(0), 100);
        send(0, 77, took, sf, sp, bc);
        check("R2 scalar while queue full", int'(sf), 1);
        for (int i = 0; i < DEPTH; i++) begin
            take(0, got);
            check("R5 order after stall", got, 100 + i);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule